// File: doc/BRIEF.md
# Packed Byte Compare-to-Register Unit

This execution unit accepts one instruction word per cycle together with the two 32-bit operand values read for it. It recognises a packed unsigned byte compare in two encodings: a 32-bit standard form and a 32-bit compact form. Both encodings select one of three conditions: equal, unsigned less-than and unsigned less-or-equal. The unit splits each operand into four 8-bit lanes and compares every lane of the first source against the same lane of the second source. It returns the four flags twice. They go to the destination register as a zero-extended value, and they go into a 4-bit slice of the condition-code field in a 32-bit DSP control register that the unit holds.

A word that is not a recognised compare raises the reserved-instruction exception. A recognised compare issued while the DSP enable input is low raises the DSP-disabled exception. In both cases nothing is written. All outputs are registered and update on the rising edge at which the valid strobe is sampled high.

Top module: `pbyte_cmp_unit`

## Requirements
- R1: Under the equal condition, flag bit i of the result is 1 when byte lane i of `srcS` equals byte lane i of `srcT`. Lane 0 is bits 7..0 and lane 3 is bits 31..24, so lane 3's flag lands in result bit 3 and lane 0's flag in result bit 0.
- R2: Under the less-than condition, flag bit i is 1 when lane i of `srcS` is below lane i of `srcT`, both read as unsigned 8-bit numbers.
- R3: Under the less-or-equal condition, flag bit i is 1 when lane i of `srcS` is at most lane i of `srcT`, both read as unsigned 8-bit numbers.
- R4: On a committed compare, `wrData` carries the four flags in bits 3..0, and every bit from 4 up to the top of the 64-bit value is zero.
- R5: On a committed compare, the same four flags are written to `dspCtrl` bits 27..24. Bits 31..28 and 23..0 of `dspCtrl` keep their previous value.
- R6: Standard form: bits 31..26 = 011111 and bits 5..0 = 010001. The source-S index is in bits 25..21, the source-T index in 20..16, the destination index in 15..11 and the selector in 10..6. Selector 11000 means equal, 11001 less-than and 11010 less-or-equal.
- R7: Compact form: bits 31..26 = 000000 and bit 10 = 0. The source-T index is in bits 25..21, the source-S index in 20..16, the destination index in 15..11 and the minor code in 9..0. Minor 0110000101 means equal, 0111000101 less-than and 1000000101 less-or-equal. `srcSIdx` and `srcTIdx` report the decoded indices.
- R8: A valid word that matches neither form, or that has a selector or minor code outside those listed, or has bit 10 set in the compact form, sets `excReserved` for one cycle. Such a word writes nothing and leaves `dspCtrl` unchanged. This exception takes priority over the DSP-disabled exception.
- R9: A recognised compare issued with `dspEnable` low sets `excDspOff` for one cycle, leaves `wrEn` low and leaves `dspCtrl` unchanged.
- R10: Outputs change only at a rising edge. In the cycle after an edge where `instrValid` is low, `wrEn`, `excReserved` and `excDspOff` are 0 and `dspCtrl` holds its value.
- R11: A synchronous reset clears `dspCtrl`, `wrEn`, `wrIdx`, `srcSIdx`, `srcTIdx`, `wrData` and both exception outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instrValid | input | 1 | Instruction word and operands are valid this cycle |
| instrWord | input | 32 | Instruction word in either encoding |
| dspEnable | input | 1 | DSP instructions are permitted |
| srcS | input | 32 | Operand value compared on the left of each condition |
| srcT | input | 32 | Operand value compared on the right of each condition |
| wrEn | output | 1 | Destination register write strobe |
| wrIdx | output | 5 | Destination register index |
| srcSIdx | output | 5 | Decoded index of the left source |
| srcTIdx | output | 5 | Decoded index of the right source |
| wrData | output | 64 | Zero-extended flag vector |
| dspCtrl | output | 32 | DSP control register |
| excReserved | output | 1 | Reserved-instruction exception |
| excDspOff | output | 1 | DSP-disabled exception |

## Verification
The hardest state to reach is a word that is both malformed and issued with the DSP unit disabled. Here the exception priority decides the outcome, and only a word built with the exact compact major code, a set bit 10 or a near-miss selector exposes the ordering. The stimulus builds such near-miss words on purpose: neighbouring selector values, neighbouring minor codes and the compact form with bit 10 set, each with the enable both high and low. Byte lanes are driven to 0x00 and 0xFF against each other and to equal values, so that the unsigned reading and the boundary between less-than and less-or-equal show up at the ports.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_LT = 2'd1,
    CMP_LE = 2'd2,
    CMP_NONE = 2'd3
  } cmpCond_e;

  typedef struct packed {
    logic     commit;
    logic     flagRsvd;
    logic     flagDspOff;
    cmpCond_e cond;
    logic [4:0] dstIdx;
    logic [4:0] sIdx;
    logic [4:0] tIdx;
  } ctrlStrobe_t;

  localparam logic [5:0] STD_MAJOR = 6'b011111;
  localparam logic [5:0] STD_FUNC  = 6'b010001;
  localparam logic [4:0] STD_SEL_EQ = 5'b11000;
  localparam logic [4:0] STD_SEL_LT = 5'b11001;
  localparam logic [4:0] STD_SEL_LE = 5'b11010;

  localparam logic [5:0] CMP_MAJOR = 6'b000000;
  localparam logic [9:0] CMP_MIN_EQ = 10'b0110000101;
  localparam logic [9:0] CMP_MIN_LT = 10'b0111000101;
  localparam logic [9:0] CMP_MIN_LE = 10'b1000000101;

endpackage

// File: rtl/pbc_lane_cmp.sv
module pbc_lane_cmp
  import pbc_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] laneS,
  input  logic [LANE_W-1:0] laneT,
  input  cmpCond_e          cond,
  output logic              flag
);

  always_comb begin
    unique case (cond)
      CMP_EQ:  flag = (laneS == laneT);
      CMP_LT:  flag = (laneS < laneT);
      CMP_LE:  flag = (laneS <= laneT);
      default: flag = 1'b0;
    endcase
  end

endmodule

// File: rtl/pbc_ctrl.sv
module pbc_ctrl
  import pbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        instrValid,
  input  logic [31:0] instrWord,
  input  logic        dspEnable,
  output ctrlStrobe_t strobe
);

  logic [5:0] major;
  logic       isStd;
  logic       isCmp;
  cmpCond_e   stdCond;
  cmpCond_e   cmpCond;
  cmpCond_e   pickCond;
  logic       known;

  assign major = instrWord[31:26];
  assign isStd = (major == STD_MAJOR) && (instrWord[5:0] == STD_FUNC);
  assign isCmp = (major == CMP_MAJOR) && !instrWord[10];

  always_comb begin
    unique case (instrWord[10:6])
      STD_SEL_EQ: stdCond = CMP_EQ;
      STD_SEL_LT: stdCond = CMP_LT;
      STD_SEL_LE: stdCond = CMP_LE;
      default:    stdCond = CMP_NONE;
    endcase
  end

  always_comb begin
    unique case (instrWord[9:0])
      CMP_MIN_EQ: cmpCond = CMP_EQ;
      CMP_MIN_LT: cmpCond = CMP_LT;
      CMP_MIN_LE: cmpCond = CMP_LE;
      default:    cmpCond = CMP_NONE;
    endcase
  end

  always_comb begin
    if (isStd)      pickCond = stdCond;
    else if (isCmp) pickCond = cmpCond;
    else            pickCond = CMP_NONE;
  end

  assign known = (pickCond != CMP_NONE);

  always_comb begin
    strobe            = '0;
    strobe.cond       = pickCond;
    strobe.dstIdx     = instrWord[15:11];
    strobe.sIdx       = isStd ? instrWord[25:21] : instrWord[20:16];
    strobe.tIdx       = isStd ? instrWord[20:16] : instrWord[25:21];
    strobe.commit     = instrValid && known && dspEnable;
    strobe.flagRsvd   = instrValid && !known;
    strobe.flagDspOff = instrValid && known && !dspEnable;
  end

  // R9: a disabled unit never commits
  a_r9_off_no_commit: assert property (@(posedge clk) disable iff (rst)
    (instrValid && !dspEnable) |-> !strobe.commit);

  // R10: nothing is issued without the valid strobe
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !instrValid |-> !(strobe.commit || strobe.flagRsvd || strobe.flagDspOff));

endmodule

// File: rtl/pbc_datapath.sv
module pbc_datapath
  import pbc_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int DATA_W = 64,
  parameter int CTRL_W = 32,
  parameter int CC_LSB = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  ctrlStrobe_t             strobe,
  input  logic [LANES*LANE_W-1:0] srcS,
  input  logic [LANES*LANE_W-1:0] srcT,
  output logic                    wrEn,
  output logic [4:0]              wrIdx,
  output logic [4:0]              srcSIdx,
  output logic [4:0]              srcTIdx,
  output logic [DATA_W-1:0]       wrData,
  output logic [CTRL_W-1:0]       dspCtrl,
  output logic                    excReserved,
  output logic                    excDspOff
);

  localparam logic [CTRL_W-1:0] CC_MASK =
    CTRL_W'((1 << LANES) - 1) << CC_LSB;

  logic [LANES-1:0] flags;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    pbc_lane_cmp #(.LANE_W(LANE_W)) u_lane (
      .laneS (srcS[gi*LANE_W +: LANE_W]),
      .laneT (srcT[gi*LANE_W +: LANE_W]),
      .cond  (strobe.cond),
      .flag  (flags[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrEn        <= 1'b0;
      excReserved <= 1'b0;
      excDspOff   <= 1'b0;
      wrIdx       <= '0;
      srcSIdx     <= '0;
      srcTIdx     <= '0;
      wrData      <= '0;
      dspCtrl     <= '0;
    end else begin
      wrEn        <= strobe.commit;
      excReserved <= strobe.flagRsvd;
      excDspOff   <= strobe.flagDspOff;
      if (strobe.commit) begin
        wrIdx                    <= strobe.dstIdx;
        srcSIdx                  <= strobe.sIdx;
        srcTIdx                  <= strobe.tIdx;
        wrData                   <= DATA_W'(flags);
        dspCtrl[CC_LSB +: LANES] <= flags;
      end
    end
  end

  // R5: both copies of the flags agree after a write
  a_r5_cc_mirror: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> (dspCtrl[CC_LSB +: LANES] == wrData[LANES-1:0]));

  // R5: bits outside the flag slice never move
  a_r5_other_bits_keep: assert property (@(posedge clk) disable iff (rst)
    strobe.commit |=> ((dspCtrl & ~CC_MASK) == ($past(dspCtrl) & ~CC_MASK)));

  // R4: upper destination bits are zero
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> ((wrData >> LANES) == '0));

  // R8: a write and an exception never coincide
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wrEn, excReserved, excDspOff}));

  // R10: control register holds without a commit
  a_r10_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.commit |=> $stable(dspCtrl));

endmodule

// File: rtl/pbyte_cmp_unit.sv
module pbyte_cmp_unit
  import pbc_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int DATA_W = 64,
  parameter int CTRL_W = 32,
  parameter int CC_LSB = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    instrValid,
  input  logic [31:0]             instrWord,
  input  logic                    dspEnable,
  input  logic [LANES*LANE_W-1:0] srcS,
  input  logic [LANES*LANE_W-1:0] srcT,
  output logic                    wrEn,
  output logic [4:0]              wrIdx,
  output logic [4:0]              srcSIdx,
  output logic [4:0]              srcTIdx,
  output logic [DATA_W-1:0]       wrData,
  output logic [CTRL_W-1:0]       dspCtrl,
  output logic                    excReserved,
  output logic                    excDspOff
);

  ctrlStrobe_t strobe;

  pbc_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .dspEnable  (dspEnable),
    .strobe     (strobe)
  );

  pbc_datapath #(
    .LANES  (LANES),
    .LANE_W (LANE_W),
    .DATA_W (DATA_W),
    .CTRL_W (CTRL_W),
    .CC_LSB (CC_LSB)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .srcS        (srcS),
    .srcT        (srcT),
    .wrEn        (wrEn),
    .wrIdx       (wrIdx),
    .srcSIdx     (srcSIdx),
    .srcTIdx     (srcTIdx),
    .wrData      (wrData),
    .dspCtrl     (dspCtrl),
    .excReserved (excReserved),
    .excDspOff   (excDspOff)
  );

endmodule

// File: tb/pbyte_cmp_unit_bench.sv
`timescale 1ns/1ps
module pbyte_cmp_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic        dspEnable = 1'b0;
  logic [31:0] srcS = '0;
  logic [31:0] srcT = '0;
  logic        wrEn;
  logic [4:0]  wrIdx, srcSIdx, srcTIdx;
  logic [63:0] wrData;
  logic [31:0] dspCtrl;
  logic        excReserved, excDspOff;

  int total = 0;
  int failed = 0;

  logic [4:0]  mIdx = '0, mSI = '0, mTI = '0;
  logic [63:0] mData = '0;
  logic [31:0] mCtrl = '0;
  logic        mW = 1'b0, mR = 1'b0, mD = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #2 clk = ~clk;

  pbyte_cmp_unit u_pbyte_cmp_unit (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instrWord(instrWord),
    .dspEnable(dspEnable), .srcS(srcS), .srcT(srcT), .wrEn(wrEn),
    .wrIdx(wrIdx), .srcSIdx(srcSIdx), .srcTIdx(srcTIdx), .wrData(wrData),
    .dspCtrl(dspCtrl), .excReserved(excReserved), .excDspOff(excDspOff)
  );

  function automatic logic [31:0] stdWord(input logic [4:0] sel, input logic [4:0] s,
                                          input logic [4:0] t, input logic [4:0] d);
    return {6'b011111, s, t, d, sel, 6'b010001};
  endfunction

  function automatic logic [31:0] cmpWord(input logic [9:0] minor, input logic [4:0] s,
                                          input logic [4:0] t, input logic [4:0] d);
    return {6'b000000, t, s, d, 1'b0, minor};
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    chk(tag, "wrEn", 64'(wrEn), 64'(mW));
    chk(tag, "excReserved", 64'(excReserved), 64'(mR));
    chk(tag, "excDspOff", 64'(excDspOff), 64'(mD));
    chk(tag, "wrIdx", 64'(wrIdx), 64'(mIdx));
    chk(tag, "srcSIdx", 64'(srcSIdx), 64'(mSI));
    chk(tag, "srcTIdx", 64'(srcTIdx), 64'(mTI));
    chk(tag, "wrData", wrData, mData);
    chk(tag, "dspCtrl", 64'(dspCtrl), 64'(mCtrl));
  endtask

  // behavioural reference: what the next edge should produce
  task automatic model(input logic [31:0] iw, input logic [31:0] s, input logic [31:0] t,
                       input logic en, input logic v);
    int cond = -1;
    logic [4:0] si = '0, ti = '0;
    logic [3:0] f = '0;
    if (iw[31:26] == 6'h1F && iw[5:0] == 6'h11) begin
      si = iw[25:21]; ti = iw[20:16];
      if (iw[10:6] == 5'h18) cond = 0;
      else if (iw[10:6] == 5'h19) cond = 1;
      else if (iw[10:6] == 5'h1A) cond = 2;
    end else if (iw[31:26] == 6'h00 && iw[10] == 1'b0) begin
      ti = iw[25:21]; si = iw[20:16];
      if (iw[9:0] == 10'h185) cond = 0;
      else if (iw[9:0] == 10'h1C5) cond = 1;
      else if (iw[9:0] == 10'h205) cond = 2;
    end
    mW = 1'b0; mR = 1'b0; mD = 1'b0;
    if (v) begin
      if (cond < 0) mR = 1'b1;
      else if (!en) mD = 1'b1;
      else begin
        for (int i = 0; i < 4; i++) begin
          int a = int'(s[i*8 +: 8]);
          int b = int'(t[i*8 +: 8]);
          f[i] = (cond == 0) ? (a == b) : (cond == 1) ? (a < b) : (a <= b);
        end
        mW = 1'b1; mIdx = iw[15:11]; mSI = si; mTI = ti;
        mData = {60'd0, f};
        mCtrl[27:24] = f;
      end
    end
  endtask

  task automatic step(input logic [31:0] iw, input logic [31:0] s, input logic [31:0] t,
                      input logic en, input logic v, input string tag);
    instrWord = iw; srcS = s; srcT = t; dspEnable = en; instrValid = v;
    model(iw, s, t, en, v);
    @(posedge clk); #1;
    compareAll(tag);
  endtask

  task automatic doReset(input string tag);
    rst = 1'b1; instrValid = 1'b0;
    @(posedge clk); #1;
    mW = 0; mR = 0; mD = 0; mIdx = 0; mSI = 0; mTI = 0; mData = 0; mCtrl = 0;
    compareAll(tag);
    rst = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    @(posedge clk); #1;
    doReset("R11");

    // R1 equal, standard form, lane order
    step(stdWord(5'h18, 5'd3, 5'd4, 5'd9), 32'h11223344, 32'h11993344, 1, 1, "R1");
    step(stdWord(5'h18, 5'd1, 5'd2, 5'd31), 32'hFF000000, 32'hFF0000FF, 1, 1, "R1");
    // R2 unsigned less-than at extremes
    step(stdWord(5'h19, 5'd5, 5'd6, 5'd7), 32'h00FF7F80, 32'hFF00807F, 1, 1, "R2");
    step(stdWord(5'h19, 5'd5, 5'd6, 5'd7), 32'h12345678, 32'h12345678, 1, 1, "R2");
    // R3 less-or-equal boundary
    step(stdWord(5'h1A, 5'd8, 5'd9, 5'd10), 32'h12345678, 32'h12345678, 1, 1, "R3");
    step(stdWord(5'h1A, 5'd8, 5'd9, 5'd10), 32'hFF010080, 32'hFE01FF7F, 1, 1, "R3");
    // R7 compact form, swapped index fields
    step(cmpWord(10'h185, 5'd12, 5'd20, 5'd2), 32'hA5A5A5A5, 32'hA5A5005A, 1, 1, "R7");
    step(cmpWord(10'h1C5, 5'd17, 5'd3, 5'd4), 32'h00000001, 32'hFFFFFF00, 1, 1, "R7");
    step(cmpWord(10'h205, 5'd30, 5'd1, 5'd0), 32'h80808080, 32'h807F8180, 1, 1, "R7");
    // R6 standard indices
    step(stdWord(5'h18, 5'd21, 5'd22, 5'd23), 32'h0, 32'h0, 1, 1, "R6");
    // R4 all flags set, upper bits zero
    step(stdWord(5'h1A, 5'd1, 5'd1, 5'd1), 32'h00000000, 32'hFFFFFFFF, 1, 1, "R4");
    // R8 reserved words, enable high and low
    step(stdWord(5'h1B, 5'd1, 5'd2, 5'd3), 32'h0, 32'h0, 1, 1, "R8");
    step(stdWord(5'h17, 5'd1, 5'd2, 5'd3), 32'h0, 32'h0, 0, 1, "R8");
    step(cmpWord(10'h185, 5'd1, 5'd2, 5'd3) | 32'h400, 32'h0, 32'h0, 1, 1, "R8");
    step(cmpWord(10'h184, 5'd1, 5'd2, 5'd3), 32'h0, 32'h0, 0, 1, "R8");
    step(stdWord(5'h18, 5'd1, 5'd2, 5'd3) ^ 32'h1, 32'h0, 32'h0, 1, 1, "R8");
    step(32'hFFFFFFFF, 32'h0, 32'h0, 1, 1, "R8");
    // R9 disabled unit
    step(stdWord(5'h18, 5'd1, 5'd2, 5'd3), 32'h0, 32'h0, 0, 1, "R9");
    step(cmpWord(10'h205, 5'd1, 5'd2, 5'd3), 32'h0, 32'hFF, 0, 1, "R9");
    // R10 idle cycles keep state
    step(stdWord(5'h18, 5'd1, 5'd2, 5'd3), 32'h0, 32'h0, 1, 0, "R10");
    step(32'h0, 32'h0, 32'h0, 0, 0, "R10");
    // R5 control slice updates, other bits stay
    step(stdWord(5'h19, 5'd1, 5'd2, 5'd3), 32'h01020304, 32'h02020204, 1, 1, "R5");

    for (int n = 0; n < 400; n++) begin
      logic [31:0] w, s, t;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      s = lfsr;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      t = lfsr[0] ? {s[31:16], lfsr[15:0]} : lfsr;
      case (lfsr[19:17])
        3'd0: w = stdWord(5'h18 + 5'(lfsr[21:20]), lfsr[26:22], s[4:0], t[4:0]);
        3'd1: w = cmpWord(10'h185, lfsr[26:22], s[4:0], t[4:0]);
        3'd2: w = cmpWord(10'h1C5, lfsr[26:22], s[4:0], t[4:0]);
        3'd3: w = cmpWord(10'h205, lfsr[26:22], s[4:0], t[4:0]);
        3'd4: w = stdWord(5'h1A, lfsr[26:22], s[4:0], t[4:0]);
        default: w = lfsr ^ t;
      endcase
      step(w, s, t, lfsr[30:27] != 4'd0, lfsr[31:30] != 2'd0, "R10");
    end

    doReset("R11");
    finishRun();
  end

endmodule